// File: doc/BRIEF.md
# Four-Channel Shared-Period PWM Timer

This block produces four pulse-width-modulated outputs from one time base. A programmable divider turns the system clock into count ticks, and a single down-counter walks from a reload value to zero and then starts again. Because every channel watches the same counter, all four outputs always have the same period. Each channel compares the counter against its own threshold, so each output can have a different duty.

Software programs the block through a plain synchronous register port. A write is taken on any clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. Each channel has an enable, a polarity bit, a mode code and an optional buffered threshold. The reload value can also be buffered. A master output gate must be open before any channel drives its active level.

The register address map is:

- 0: control. Bit 0 runs the time base. Bit 1 buffers the reload value.
- 1: divider.
- 2: reload value.
- 3: channel configuration.
- 4: mode register A.
- 5: mode register B.
- 6: master gate, at bit 15.
- 7: live counter, read only.
- 8 to 11: thresholds for channels 1 to 4.

Top module: `pwm4_timer`

## Requirements
- R1: The counter moves once every DIV+1 clock cycles while control bit 0 is set, and it holds while that bit is clear.
- R2: The counter decrements by one per tick. On the tick where it is 0, it loads the reload value, so the period is (RELOAD+1)*(DIV+1) clocks.
- R3: All four channels share one counter, so for every configuration they show the same period.
- R4: In PWM mode (code 3'b110), a channel is active while the counter is below its threshold. A threshold of 0 gives an output that is never active. A threshold above the reload value gives an output that is always active.
- R5: The channel configuration register holds each channel's enable at bits 0, 4, 8 and 12. A disabled channel drives its inactive level.
- R6: When control bit 1 is set, a new reload value is captured at a reload event and is first loaded into the counter at the reload event after that. When the bit is clear, the next reload uses the register directly.
- R7: Mode field bit 3 buffers that channel's threshold. When it is set, a new threshold takes effect only after the next reload event. When it is clear, a new threshold takes effect at once.
- R8: Mode register A bits [7:0] configure channel 1 and bits [15:8] configure channel 2. Mode register B does the same for channels 3 and 4. Mode code 3'b101 forces the output active, 3'b100 forces it inactive, and any code other than 3'b110 is inactive.
- R9: The polarity bits sit at bits 1, 5, 9 and 13 of the channel configuration register. A set bit inverts the output: the active level becomes 0 and the inactive level becomes 1, so a duty of d turns into 1-d.
- R10: While the master gate (bit 15 at address 6) is clear, every output sits at its inactive level.
- R11: After reset, every register and the counter read 0 and all outputs are 0.
- R12: Every writable register reads back the value written to it, and address 7 returns the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| pwm_out | output | 4 | Channel outputs, bit 0 is channel 1 |

## Verification
The assertions do not restrict when software writes: they hold when the divider, the reload value or a threshold changes in the middle of a period. This is why the prescaler resets on `pcnt >= div` rather than on equality. They only assume that the register inputs carry known values whenever `reg_wr` is high. The stimulus changes configuration only outside its measurement windows. After each change it waits longer than two worst-case periods before it counts active cycles, so every window covers whole, steady periods. The buffering tests time their writes against the counter value read from address 7.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  // register map
  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_DIV    = 1;
  localparam int unsigned A_RELOAD = 2;
  localparam int unsigned A_CHCFG  = 3;
  localparam int unsigned A_MODE0  = 4;
  localparam int unsigned A_MASTER = 6;
  localparam int unsigned A_COUNT  = 7;
  localparam int unsigned A_CMP0   = 8;

  localparam int CTRL_RUN     = 0;
  localparam int CTRL_ARPE    = 1;
  localparam int EN_STRIDE    = 4;
  localparam int POL_OFS      = 1;
  localparam int MODE_FIELD_W = 8;
  localparam int MODE_CFG_W   = 4;
  localparam int PRELOAD_BIT  = 3;
  localparam int MOE_BIT      = 15;

  typedef enum logic [2:0] {
    OCM_IDLE     = 3'b000,
    OCM_FORCE_LO = 3'b100,
    OCM_FORCE_HI = 3'b101,
    OCM_PWM      = 3'b110
  } ocm_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] pcnt;

  // >= keeps a lowered divider from stalling the time base
  assign tick = run && (pcnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt <= '0;
    else if (!run || tick)  pcnt <= '0;
    else                    pcnt <= pcnt + 1'b1;
  end

  // R1
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt == '0));
  // R1
  div_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (pcnt == $past(pcnt) + 1'b1));
endmodule

// File: rtl/pwm_downcounter.sv
module pwm_downcounter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         arpe,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         upd
);
  logic [W-1:0] reload_shadow;
  logic [W-1:0] reload_eff;

  assign reload_eff = arpe ? reload_shadow : reload;
  assign upd        = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      reload_shadow <= '0;
    end else if (upd) begin
      cnt           <= reload_eff;
      reload_shadow <= reload;
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R6
  count_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt == $past(reload_eff)));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic [W-1:0]          cnt,
  input  logic [W-1:0]          cmp,
  input  logic [MODE_CFG_W-1:0] mode_cfg,
  input  logic                  en,
  input  logic                  pol,
  input  logic                  moe,
  output logic                  out
);
  logic [W-1:0] cmp_shadow;
  logic [W-1:0] cmp_eff;
  logic         pre;
  logic         act;
  ocm_e         mode;

  assign pre     = mode_cfg[PRELOAD_BIT];
  assign mode    = ocm_e'(mode_cfg[2:0]);
  assign cmp_eff = pre ? cmp_shadow : cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cmp_shadow <= '0;
    else if (upd) cmp_shadow <= cmp;
  end

  always_comb begin
    unique case (mode)
      OCM_PWM:      act = (cnt < cmp_eff);
      OCM_FORCE_HI: act = 1'b1;
      default:      act = 1'b0;
    endcase
    out = (en && moe) ? (act ^ pol) : pol;
  end

  // R10
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !moe |-> (out == pol));
  // R7
  cmp_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && pre) |=> (!pre || cmp_eff == $past(cmp)));
endmodule

// File: rtl/pwm4_timer.sv
module pwm4_timer
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int NUM_MODE = (NUM_CH + 1) / 2;

  logic [1:0]    ctrl_q;
  logic [DW-1:0] div_q;
  logic [DW-1:0] reload_q;
  logic [DW-1:0] chcfg_q;
  logic [DW-1:0] mode_q [NUM_MODE];
  logic [DW-1:0] cmp_q  [NUM_CH];
  logic          moe_q;

  logic          tick;
  logic          upd;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      div_q    <= '0;
      reload_q <= '0;
      chcfg_q  <= '0;
      moe_q    <= 1'b0;
      for (int m = 0; m < NUM_MODE; m++) mode_q[m] <= '0;
      for (int c = 0; c < NUM_CH; c++)   cmp_q[c]  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == AW'(A_CTRL))   ctrl_q   <= reg_wdata[1:0];
      if (reg_addr == AW'(A_DIV))    div_q    <= reg_wdata;
      if (reg_addr == AW'(A_RELOAD)) reload_q <= reg_wdata;
      if (reg_addr == AW'(A_CHCFG))  chcfg_q  <= reg_wdata;
      if (reg_addr == AW'(A_MASTER)) moe_q    <= reg_wdata[MOE_BIT];
      for (int m = 0; m < NUM_MODE; m++)
        if (reg_addr == AW'(A_MODE0 + m)) mode_q[m] <= reg_wdata;
      for (int c = 0; c < NUM_CH; c++)
        if (reg_addr == AW'(A_CMP0 + c)) cmp_q[c] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CTRL))   reg_rdata[1:0]    = ctrl_q;
    if (reg_addr == AW'(A_DIV))    reg_rdata         = div_q;
    if (reg_addr == AW'(A_RELOAD)) reg_rdata         = reload_q;
    if (reg_addr == AW'(A_CHCFG))  reg_rdata         = chcfg_q;
    if (reg_addr == AW'(A_MASTER)) reg_rdata[MOE_BIT] = moe_q;
    if (reg_addr == AW'(A_COUNT))  reg_rdata         = cnt;
    for (int m = 0; m < NUM_MODE; m++)
      if (reg_addr == AW'(A_MODE0 + m)) reg_rdata = mode_q[m];
    for (int c = 0; c < NUM_CH; c++)
      if (reg_addr == AW'(A_CMP0 + c)) reg_rdata = cmp_q[c];
  end

  pwm_prescaler #(.W(DW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl_q[CTRL_RUN]),
    .div  (div_q),
    .tick (tick)
  );

  pwm_downcounter #(.W(DW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .arpe  (ctrl_q[CTRL_ARPE]),
    .reload(reload_q),
    .cnt   (cnt),
    .upd   (upd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.W(DW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (upd),
      .cnt     (cnt),
      .cmp     (cmp_q[c]),
      .mode_cfg(mode_q[c/2][(c%2)*MODE_FIELD_W +: MODE_CFG_W]),
      .en      (chcfg_q[c*EN_STRIDE]),
      .pol     (chcfg_q[c*EN_STRIDE + POL_OFS]),
      .moe     (moe_q),
      .out     (pwm_out[c])
    );
  end
endmodule

// File: tb/tb_pwm4_timer.sv
module tb_pwm4_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm4_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic wait_cnt(input int v);
    int d;
    do rd(7, d); while (d != v);
  endtask

  task automatic next_cnt(output int d);
    rd(7, d);
  endtask

  task automatic expect_out(input logic [3:0] e, input string req);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      check(pwm_out == e, req, int'(pwm_out), int'(e));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d, prev, n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int a = 0; a < 12; a++) begin
      rd(a, d);
      check(d == 0, "R11", d, 0);
    end
    #1 check(pwm_out == 4'b0000, "R11", int'(pwm_out), 0);

    // R12 readback
    wr(4, 16'hA5C3); rd(4, d); check(d == 16'hA5C3, "R12", d, 16'hA5C3);
    wr(10, 16'h1234); rd(10, d); check(d == 16'h1234, "R12", d, 16'h1234);
    wr(6, 16'h8000); rd(6, d); check(d == 16'h8000, "R12", d, 16'h8000);

    // R1 / R2: divider stride and reload value
    wr(4, 0); wr(2, 5); wr(0, 1);
    for (int p = 0; p < 4; p++) begin
      wr(1, p);
      repeat (40) @(negedge clk);
      rd(7, prev);
      do begin rd(7, d); end while (d == prev);
      n = 0; prev = d;
      do begin rd(7, d); n++; end while (d == prev);
      check(n == p + 1, "R1", n, p + 1);
    end
    wr(1, 2);
    wait_cnt(0);
    do rd(7, d); while (d == 0);
    check(d == 5, "R2", d, 5);
    // R1 hold while stopped
    wr(0, 0); rd(7, prev); repeat (10) @(negedge clk); rd(7, d);
    check(d == prev, "R1", d, prev);

    // R3 R4 R9 duty sweep over divider, reload, thresholds and polarity
    wr(4, 16'h0606); wr(5, 16'h0606); wr(6, 16'h8000); wr(0, 1);
    for (int psc = 0; psc < 3; psc++)
      for (int arr = 3; arr < 6; arr++)
        for (int r = 0; r < 2; r++) begin
          int cmpv [4];
          int cnt_hi [4];
          int cfg, win;
          cfg = 0;
          for (int j = 0; j < 4; j++) begin
            cmpv[j] = (j + r * 4) % (arr + 3);
            wr(8 + j, cmpv[j]);
            cfg |= (1 | (((j + r) & 1) << 1)) << (4 * j);
            cnt_hi[j] = 0;
          end
          wr(1, psc); wr(2, arr); wr(3, cfg);
          repeat (40) @(negedge clk);
          win = 2 * (psc + 1) * (arr + 1);
          for (int k = 0; k < win; k++) begin
            @(negedge clk); #1;
            for (int j = 0; j < 4; j++) cnt_hi[j] += int'(pwm_out[j]);
          end
          for (int j = 0; j < 4; j++) begin
            int hi, e;
            hi = 2 * (psc + 1) * ((cmpv[j] < arr + 1) ? cmpv[j] : arr + 1);
            e = (((j + r) & 1) != 0) ? win - hi : hi;
            check(cnt_hi[j] == e, (((j + r) & 1) != 0) ? "R9" : "R4/R3",
                  cnt_hi[j], e);
          end
        end

    // R6 reload buffering
    wr(1, 0); wr(2, 9); wr(0, 3);
    repeat (30) @(negedge clk);
    wait_cnt(5); wr(2, 3);
    wait_cnt(0); next_cnt(d); check(d == 9, "R6", d, 9);
    wait_cnt(0); next_cnt(d); check(d == 3, "R6", d, 3);
    wr(0, 1);
    wait_cnt(3); wr(2, 9);
    wait_cnt(0); next_cnt(d); check(d == 9, "R6", d, 9);

    // R7 threshold buffering on channel 1
    wr(3, 1); wr(8, 2); wr(4, 16'h000E);
    repeat (30) @(negedge clk);
    wait_cnt(8); wr(8, 8);
    wait_cnt(5); #1 check(pwm_out[0] == 1'b0, "R7", int'(pwm_out[0]), 0);
    wait_cnt(0); wait_cnt(5); #1 check(pwm_out[0] == 1'b1, "R7", int'(pwm_out[0]), 1);
    wr(4, 16'h0006);
    repeat (30) @(negedge clk);
    wait_cnt(8); wr(8, 2);
    wait_cnt(5); #1 check(pwm_out[0] == 1'b0, "R7", int'(pwm_out[0]), 0);

    // R8 mode fields and forced codes
    wr(2, 5); wr(9, 20);
    wr(4, 16'h0600); wr(5, 16'h0405); wr(3, 16'h1111);
    expect_out(4'b0110, "R8");
    // R9 inverted levels
    wr(3, 16'h3333);
    expect_out(4'b1001, "R9");
    // R5 disabled channels sit at inactive level
    wr(3, 16'h2220);
    expect_out(4'b1110, "R5");
    wr(4, 16'h0505); wr(5, 16'h0505); wr(3, 16'h0100);
    expect_out(4'b0100, "R5");
    // R10 master gate closed
    wr(3, 16'h1131); wr(6, 0);
    expect_out(4'b0010, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule